// File: doc/BRIEF.md
# Narrow Asynchronous SRAM Word Bridge

This block lets a core issue 32-bit word reads and writes against an external asynchronous static memory whose data bus is only 16 or 8 bits wide. A width-select input, sampled with each request, picks the read mode. A read is split into two halfword or four byte accesses. They run one after another, and the result is packed into a big-endian word. A write is always carried out as two halfword write cycles, upper half first. Each of those cycles has a setup phase, a write-enable phase and a hold phase, so that the memory sees stable address and data around its write strobe. Byte enables from the request mask the two byte lanes.

The core side uses a simple request/acknowledge handshake. The memory side drives address, write data with a separate drive enable, two active-low byte write strobes and an active-low output enable. Each memory pin comes from a flop, or from a flop through at most one 2-to-1 multiplexer. A 3-bit wait-state value, given with each request, sets the length of every access phase. This lets the same block serve both fast and slow memories.

Top module: `sram_bridge`

## Requirements
- R1: During and after reset, with no request pending, `ack` is 0, `mem_oe_n` is 1, `mem_we_n` is 11 and `mem_dout_en` is 0.
- R2: A read with `wide_mode`=1 performs two accesses. The first drives `mem_addr[1:0]`=00, and its 16-bit data becomes word bits 31:16. The second drives 10, and its data becomes bits 15:0. `ack` comes 2·(ws+1) cycles after acceptance, counting the acceptance edge as cycle 1's start.
- R3: A read with `wide_mode`=0 performs four accesses at `mem_addr[1:0]` = 00, 01, 10, 11, in that order. Each uses `mem_din[7:0]` only and fills word bits 31:24, 23:16, 15:8 and 7:0 respectively. `ack` comes 4·(ws+1) cycles after acceptance.
- R4: Every wait-timed phase lasts ws+1 cycles. A 3-bit down-counter is loaded with ws on phase entry, steps down while nonzero, and the phase ends in the cycle it reads zero. Both ws=0 and ws=7 give exactly those lengths.
- R5: A write runs two halfword sequences regardless of `wide_mode`. The first is at `mem_addr[1:0]`=00 with `req_wdata[31:16]`; the second is at 10 with `req_wdata[15:0]`. Each sequence has a 1-cycle setup, ws+1 cycles of strobe, and a 1-cycle hold. `ack` comes 2·(ws+3) cycles after acceptance.
- R6: `mem_we_n` is ~`req_be[3:2]` during the first strobe phase and ~`req_be[1:0]` during the second, and 11 at all other times. `mem_we_n[1]` strobes data lane 15:8 and `mem_we_n[0]` strobes lane 7:0, so bytes whose enable is 0 stay unchanged in memory.
- R7: `mem_oe_n` is 0 only while a read access is in progress; it stays 1 during writes and while idle.
- R8: `mem_dout_en` is 1 only during the setup, strobe and hold phases of a write. `mem_dout` and `mem_addr` do not change within one halfword sequence.
- R9: `mem_addr[ADDR_W-1:2]` equals the accepted `req_word_addr` and stays constant for the whole access.
- R10: A request is taken only while the block is idle. A request raised during an access starts nothing and writes nothing.
- R11: `ack` is a single-cycle pulse. On a read, `rdata` is valid in that cycle, and its last halfword or byte is taken combinationally from `mem_din`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| wide_mode | input | 1 | Read width: 1 = 16-bit memory, 0 = 8-bit memory |
| req_word_addr | input | ADDR_W-2 | Word address of the request |
| req_be | input | 4 | Byte enables for a write, bit 3 = bits 31:24 |
| req_wdata | input | 32 | Write word |
| req_ws | input | 3 | Wait states per access phase |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Assembled read word, valid with ack |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_dout | output | 16 | Memory write data |
| mem_dout_en | output | 1 | Drive enable for mem_dout |
| mem_we_n | output | 2 | Active-low byte write strobes (bit 1 = lane 15:8) |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_din | input | 16 | Memory read data (not registered on entry) |

## Verification
Reads are applied in both widths at several word addresses, with wait-state values 0, 1, 3 and 7. The memory contents differ in every byte, so a swapped halfword, a reversed byte order or a wrong lane choice shows up as a wrong word, and the ack cycle count separates off-by-one phase lengths. Writes use byte-enable patterns 1111, 0101 and 1010. They are checked against a snapshot of the target halfwords, which exposes crossed strobe lanes or a wrong halfword order, and the count of strobe-active cycles measures the strobe length. A request raised mid-access tells a block that gates acceptance on idle apart from one that restarts or queues it.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;

    localparam int WORD_W = 32;
    localparam int HALF_W = 16;
    localparam int BYTE_W = 8;
    localparam int BE_W   = WORD_W / BYTE_W;
    localparam int WS_W   = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WSETUP,
        ST_WSTROBE,
        ST_WHOLD
    } bridge_state_t;

    // request fields held for the whole access
    typedef struct packed {
        logic              wide;
        logic [WS_W-1:0]   ws;
        logic [BE_W-1:0]   be;
        logic [HALF_W-1:0] wlow;
    } req_ctl_t;

    // low address bits for read phase ph
    function automatic logic [1:0] rd_lane(input logic wide, input logic [1:0] ph);
        return wide ? {ph[0], 1'b0} : ph;
    endfunction

    // true on the final read phase
    function automatic logic rd_last(input logic wide, input logic [1:0] ph);
        return wide ? ph[0] : (ph == 2'd3);
    endfunction

endpackage

// File: rtl/sram_bridge_wsctr.sv
module sram_bridge_wsctr #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);

    logic [W-1:0] ctr_q;

    always_ff @(posedge clk) begin
        if (rst)
            ctr_q <= '0;
        else if (load)
            ctr_q <= val;
        else if (ctr_q != '0)
            ctr_q <= ctr_q - 1'b1;
    end

    assign zero = (ctr_q == '0);

    // R4: a loaded value appears next cycle
    p_ws_load_r4: assert property (@(posedge clk) disable iff (rst)
        load |=> (ctr_q == $past(val)));

    // R4: without load, a nonzero count steps down by one
    p_ws_step_r4: assert property (@(posedge clk) disable iff (rst)
        (!load && !zero) |=> (ctr_q == $past(ctr_q) - 1'b1));

endmodule

// File: rtl/sram_bridge_rdpack.sv
module sram_bridge_rdpack
    import sram_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap,
    input  logic              wide,
    input  logic [1:0]        slot,
    input  logic [HALF_W-1:0] din,
    output logic [WORD_W-1:0] word
);

    localparam int NLANE  = WORD_W / BYTE_W;
    localparam int HLANES = HALF_W / BYTE_W;

    logic [WORD_W-1:BYTE_W] hold;

    // one holding byte for every lane except the last, which is never stored
    for (genvar g = 0; g < NLANE - 1; g++) begin : g_lane
        logic [BYTE_W-1:0] q;
        logic [BYTE_W-1:0] src;
        logic              ld;

        if (g < HLANES) begin : g_wide_ok
            always_comb begin
                src = wide ? din[HALF_W-1-g*BYTE_W -: BYTE_W] : din[BYTE_W-1:0];
                ld  = cap && (wide ? (slot == 2'd0) : (slot == 2'(g)));
            end
        end else begin : g_narrow_only
            always_comb begin
                src = din[BYTE_W-1:0];
                ld  = cap && !wide && (slot == 2'(g));
            end
        end

        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (ld)
                q <= src;
        end

        assign hold[WORD_W-1-g*BYTE_W -: BYTE_W] = q;
    end

    // final piece comes straight from the pins
    assign word = wide ? {hold[WORD_W-1:HALF_W], din}
                       : {hold[WORD_W-1:BYTE_W], din[BYTE_W-1:0]};

    // R3: the last byte slot is never captured
    p_cap_slot_r3: assert property (@(posedge clk) disable iff (rst)
        (cap && !wide) |-> (slot != 2'd3));

    // R2: in 16-bit mode only the first halfword is captured
    p_cap_wide_r2: assert property (@(posedge clk) disable iff (rst)
        (cap && wide) |-> (slot == 2'd0));

endmodule

// File: rtl/sram_bridge.sv
module sram_bridge
    import sram_bridge_pkg::*;
#(
    parameter int ADDR_W = 17,
    localparam int WA_W  = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              wide_mode,
    input  logic [WA_W-1:0]   req_word_addr,
    input  logic [BE_W-1:0]   req_be,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic [WS_W-1:0]   req_ws,
    output logic              ack,
    output logic [WORD_W-1:0] rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [HALF_W-1:0] mem_dout,
    output logic              mem_dout_en,
    output logic [1:0]        mem_we_n,
    output logic              mem_oe_n,
    input  logic [HALF_W-1:0] mem_din
);

    bridge_state_t   st;
    req_ctl_t        ctl;
    logic [1:0]      ph;
    logic [1:0]      ph_nx;
    logic            ws_load;
    logic [WS_W-1:0] ws_val;
    logic            ws_zero;
    logic            rd_end;
    logic            rd_fin;
    logic            cap;

    always_comb begin
        ph_nx   = ph + 2'd1;
        rd_fin  = rd_last(ctl.wide, ph);
        rd_end  = (st == ST_READ) && ws_zero;
        cap     = rd_end && !rd_fin;
        ws_load = ((st == ST_IDLE) && req_valid && !req_write)
                || cap
                || (st == ST_WSETUP);
        ws_val  = (st == ST_IDLE) ? req_ws : ctl.ws;
        ack     = (rd_end && rd_fin) || ((st == ST_WHOLD) && ph[0]);
    end

    sram_bridge_wsctr #(.W(WS_W)) u_wsctr (
        .clk  (clk),
        .rst  (rst),
        .load (ws_load),
        .val  (ws_val),
        .zero (ws_zero)
    );

    sram_bridge_rdpack u_rdpack (
        .clk  (clk),
        .rst  (rst),
        .cap  (cap),
        .wide (ctl.wide),
        .slot (ph),
        .din  (mem_din),
        .word (rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            ctl         <= '0;
            ph          <= '0;
            mem_addr    <= '0;
            mem_dout    <= '0;
            mem_dout_en <= 1'b0;
            mem_we_n    <= 2'b11;
            mem_oe_n    <= 1'b1;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        ctl      <= '{wide: wide_mode, ws: req_ws, be: req_be,
                                      wlow: req_wdata[HALF_W-1:0]};
                        ph       <= '0;
                        mem_addr <= {req_word_addr, 2'b00};
                        if (req_write) begin
                            st          <= ST_WSETUP;
                            mem_dout    <= req_wdata[WORD_W-1:HALF_W];
                            mem_dout_en <= 1'b1;
                        end else begin
                            st       <= ST_READ;
                            mem_oe_n <= 1'b0;
                        end
                    end
                end
                ST_READ: begin
                    if (ws_zero) begin
                        if (rd_fin) begin
                            st       <= ST_IDLE;
                            mem_oe_n <= 1'b1;
                        end else begin
                            ph            <= ph_nx;
                            mem_addr[1:0] <= rd_lane(ctl.wide, ph_nx);
                        end
                    end
                end
                ST_WSETUP: begin
                    st       <= ST_WSTROBE;
                    mem_we_n <= ph[0] ? ~ctl.be[1:0] : ~ctl.be[3:2];
                end
                ST_WSTROBE: begin
                    if (ws_zero) begin
                        st       <= ST_WHOLD;
                        mem_we_n <= 2'b11;
                    end
                end
                ST_WHOLD: begin
                    if (ph[0]) begin
                        st          <= ST_IDLE;
                        ph          <= '0;
                        mem_dout_en <= 1'b0;
                    end else begin
                        st            <= ST_WSETUP;
                        ph            <= 2'd1;
                        mem_addr[1:0] <= 2'b10;
                        mem_dout      <= ctl.wlow;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R7: output enable and write drive never overlap
    p_oe_vs_drive_r7: assert property (@(posedge clk) disable iff (rst)
        mem_dout_en |-> mem_oe_n);

    // R8: a write strobe only while write data is driven
    p_strobe_driven_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_we_n != 2'b11) |-> mem_dout_en);

    // R8: data and address held through strobe and hold phases
    p_dout_stable_r8: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_WSTROBE) || (st == ST_WHOLD)) |-> ($stable(mem_dout) && $stable(mem_addr)));

    // R9: upper address bits fixed during an access
    p_addr_stable_r9: assert property (@(posedge clk) disable iff (rst)
        ((st != ST_IDLE) && ($past(st) != ST_IDLE)) |-> $stable(mem_addr[ADDR_W-1:2]));

    // R11: acknowledge is a single-cycle pulse
    p_ack_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    // R6: strobes are released in the hold phase
    p_hold_release_r6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WHOLD) |-> (mem_we_n == 2'b11));

endmodule

// File: tb/sram_bridge_test.sv
`timescale 1ns/1ps
module sram_bridge_test;

    localparam int ADDR_W = 17;
    localparam int WA_W   = ADDR_W - 2;
    localparam int NVEC   = 10;

    // kind: 0 read16, 1 read8, 2 write wide_mode=1, 3 write wide_mode=0
    // fields: [48:47] kind [46:44] ws [43:36] word addr [35:32] be [31:0] data
    localparam logic [48:0] VEC [0:NVEC-1] = '{
        {2'd0, 3'd0, 8'h10, 4'h0, 32'h0},
        {2'd0, 3'd7, 8'h21, 4'h0, 32'h0},
        {2'd1, 3'd0, 8'h05, 4'h0, 32'h0},
        {2'd1, 3'd7, 8'h3F, 4'h0, 32'h0},
        {2'd0, 3'd3, 8'h7F, 4'h0, 32'h0},
        {2'd2, 3'd0, 8'h12, 4'hF, 32'h12345678},
        {2'd2, 3'd7, 8'h13, 4'h5, 32'hCAFEBABE},
        {2'd3, 3'd2, 8'h14, 4'hA, 32'h0F1E2D3C},
        {2'd0, 3'd1, 8'h12, 4'h0, 32'h0},
        {2'd1, 3'd1, 8'h00, 4'h0, 32'h0}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic              wide_mode = 1'b1;
    logic [WA_W-1:0]   req_word_addr = '0;
    logic [3:0]        req_be = '0;
    logic [31:0]       req_wdata = '0;
    logic [2:0]        req_ws = '0;
    logic              ack;
    logic [31:0]       rdata;
    logic [ADDR_W-1:0] mem_addr;
    logic [15:0]       mem_dout;
    logic              mem_dout_en;
    logic [1:0]        mem_we_n;
    logic              mem_oe_n;
    logic [15:0]       mem_din;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    sram_bridge #(.ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .wide_mode(wide_mode), .req_word_addr(req_word_addr), .req_be(req_be),
        .req_wdata(req_wdata), .req_ws(req_ws), .ack(ack), .rdata(rdata),
        .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_din(mem_din)
    );

    // behavioural asynchronous memories with a fixed access delay
    logic [15:0] hmem [0:255];
    logic [7:0]  bmem [0:255];
    logic        mem_wide = 1'b1;
    logic [15:0] din_raw;
    logic [1:0]  we_prev = 2'b11;

    always_comb begin
        if (mem_oe_n)
            din_raw = 16'hDEAD;
        else if (mem_wide)
            din_raw = hmem[mem_addr[8:1]];
        else
            din_raw = {8'hEE, bmem[mem_addr[7:0]]};
    end

    assign #3 mem_din = din_raw;

    initial begin
        for (int i = 0; i < 256; i++)
            bmem[i] = 8'(i * 7 + 17);
    end

    // memory writes latch on the rising strobe, seen at the falling clock
    always @(negedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++)
                hmem[i] <= {8'(i) ^ 8'h3C, ~8'(i)};
            we_prev <= 2'b11;
        end else begin
            if (mem_we_n[1] && !we_prev[1])
                hmem[mem_addr[8:1]][15:8] <= mem_dout[15:8];
            if (mem_we_n[0] && !we_prev[0])
                hmem[mem_addr[8:1]][7:0] <= mem_dout[7:0];
            we_prev <= mem_we_n;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] kind, input logic [2:0] ws,
                          input logic [7:0] wa, input logic [3:0] be,
                          input logic [31:0] wd);
        int cnt = 1;
        int we_cnt = 0;
        int pin_err = 0;
        int addr_err = 0;
        bit rd = (kind < 2'd2);
        logic [15:0] old0, old1, n0, n1;
        logic [31:0] exp_w;
        string tag;
        int exp_cnt;
        int exp_we;

        old0 = hmem[{wa[6:0], 1'b0}];
        old1 = hmem[{wa[6:0], 1'b1}];
        mem_wide      = (kind != 2'd1);
        req_valid     = 1'b1;
        req_write     = !rd;
        wide_mode     = (kind == 2'd0) || (kind == 2'd2);
        req_word_addr = {7'd0, wa};
        req_be        = be;
        req_wdata     = wd;
        req_ws        = ws;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!ack && cnt < 200) begin
            if (mem_we_n != 2'b11) we_cnt++;
            if (rd && (mem_dout_en || mem_oe_n || mem_we_n != 2'b11)) pin_err++;
            if (!rd && (!mem_oe_n || !mem_dout_en)) pin_err++;
            if (mem_addr[ADDR_W-1:2] != {7'd0, wa}) addr_err++;
            @(negedge clk);
            cnt++;
        end
        if (mem_addr[ADDR_W-1:2] != {7'd0, wa}) addr_err++;

        case (kind)
            2'd0: begin
                tag = "R2/R4"; exp_cnt = 2 * (int'(ws) + 1);
                exp_w = {hmem[{wa[6:0], 1'b0}], hmem[{wa[6:0], 1'b1}]};
            end
            2'd1: begin
                tag = "R3/R4"; exp_cnt = 4 * (int'(ws) + 1);
                exp_w = {bmem[{wa[5:0], 2'd0}], bmem[{wa[5:0], 2'd1}],
                         bmem[{wa[5:0], 2'd2}], bmem[{wa[5:0], 2'd3}]};
            end
            default: begin
                tag = "R5/R4"; exp_cnt = 2 * (int'(ws) + 3);
                exp_w = '0;
            end
        endcase
        check(tag, 32'(cnt), 32'(exp_cnt));
        check("R9 address", 32'(addr_err), 32'd0);
        if (rd) begin
            check({tag, " R11 data"}, rdata, exp_w);
            check("R7 read pins", 32'(pin_err), 32'd0);
        end else begin
            check("R8 write pins", 32'(pin_err), 32'd0);
            exp_we = (int'(ws) + 1) * ((be[3:2] != 2'b00 ? 1 : 0) + (be[1:0] != 2'b00 ? 1 : 0));
            check("R6 strobe cycles", 32'(we_cnt), 32'(exp_we));
            @(negedge clk);
            n0 = {be[3] ? wd[31:24] : old0[15:8], be[2] ? wd[23:16] : old0[7:0]};
            n1 = {be[1] ? wd[15:8]  : old1[15:8], be[0] ? wd[7:0]   : old1[7:0]};
            check("R5/R6 upper half", {16'd0, hmem[{wa[6:0], 1'b0}]}, {16'd0, n0});
            check("R5/R6 lower half", {16'd0, hmem[{wa[6:0], 1'b1}]}, {16'd0, n1});
        end
        @(posedge clk);
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int cnt;
        int bad;
        logic [15:0] keep0, keep1;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 ack", {31'd0, ack}, 32'd0);
        check("R1 oe_n", {31'd0, mem_oe_n}, 32'd1);
        check("R1 we_n", {30'd0, mem_we_n}, 32'd3);
        check("R1 dout_en", {31'd0, mem_dout_en}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle ack", {31'd0, ack}, 32'd0);

        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            run_op(VEC[v][48:47], VEC[v][46:44], VEC[v][43:36], VEC[v][35:32], VEC[v][31:0]);
        end

        // R10/R11: a write request during a read is ignored
        @(negedge clk);
        keep0 = hmem[8'h40];
        keep1 = hmem[8'h41];
        mem_wide = 1'b1;
        req_valid = 1'b1; req_write = 1'b0; wide_mode = 1'b1;
        req_word_addr = 15'h0020; req_ws = 3'd3;
        @(posedge clk);
        @(negedge clk);
        cnt = 1;
        req_valid = 1'b1; req_write = 1'b1; req_be = 4'hF; req_wdata = 32'h0;
        @(negedge clk);
        cnt++;
        req_valid = 1'b0;
        while (!ack && cnt < 200) begin
            @(negedge clk);
            cnt++;
        end
        check("R10 read length unchanged", 32'(cnt), 32'd8);
        check("R11 read word", rdata, {keep0, keep1});
        @(negedge clk);
        check("R11 ack single pulse", {31'd0, ack}, 32'd0);
        bad = 0;
        for (int k = 0; k < 6; k++) begin
            if (ack || mem_dout_en || mem_we_n != 2'b11 || !mem_oe_n) bad++;
            @(negedge clk);
        end
        check("R10 no queued op", 32'(bad), 32'd0);
        check("R10 memory untouched", {hmem[8'h40], hmem[8'h41]}, {keep0, keep1});

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule